// File: doc/BRIEF.md
# Stereo DSP-Mode Audio Serializer

This block sends one stereo pair of sample words per audio frame on a single serial data line, using the late DSP framing. A bit clock and a frame-sync signal come from the outside. The block samples both of them with its own system clock.

A frame begins on the bit-clock falling edge at which frame sync is seen going from low to high. On that edge the block latches the left word, the right word and the word-length select. It then drives the MSB of the left word. On each following bit-clock falling edge it drives the next bit. The left word goes out MSB first and the right word follows straight after it, also MSB first. After the last right bit the line is held low until the next frame begins.

A receiver samples the line on bit-clock rising edges. A one-cycle acknowledge strobe tells the sample source that the pair has been taken. From that moment the source may present the next pair.

Top module: `dsp_late_serializer`

## Requirements
- R1: While reset is held, and before any frame has started, `sdo` is 0 and `load_ack` is 0.
- R2: A frame starts on a bit-clock falling edge at which `fsync` is 1 and was 0 at the previous bit-clock falling edge. From that edge on, `sdo` carries the left word's MSB (bit position 0 of the frame).
- R3: `sdo` only changes in response to a bit-clock falling edge. It holds its value over the whole bit period in which it is sampled on the rising edge.
- R4: The word length comes from `wl_sel`: 2'b00 = 16 bits, 2'b01 = 20, 2'b10 = 24, 2'b11 = 32. A word of length N is taken from bits [N-1:0] of its input. The left word goes out MSB first at bit positions 0 to N-1.
- R5: The right word follows the left word with no gap. It goes out MSB first at bit positions N to 2N-1.
- R6: From bit position 2N until the next frame start, `sdo` is 0. When the next frame starts right after position 2N-1, that frame's MSB follows with no low bit in between.
- R7: `left_in`, `right_in` and `wl_sel` are latched at the frame start. Changes to them later in the frame do not alter the bits sent in that frame.
- R8: `load_ack` is high for exactly one system-clock cycle per frame start. That cycle is the first cycle in which `sdo` shows the new MSB. It is never high outside a frame start.
- R9: Frame sync held high for several bit periods starts only one frame. The frame still runs its full bit sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync; a low-to-high change marks a frame start |
| wl_sel | input | 2 | Word-length select (00=16, 01=20, 10=24, 11=32) |
| left_in | input | 32 | Left sample, right-aligned in the field |
| right_in | input | 32 | Right sample, right-aligned in the field |
| sdo | output | 1 | Serial data out, changes after bit-clock falling edges |
| load_ack | output | 1 | One-cycle strobe when a new pair is latched |

## Verification
The assertions take three things for granted:
- Each bit-clock level lasts longer than the synchronizer depth plus one system-clock cycle, so no falling edge is missed.
- Frame sync changes only together with bit-clock falling edges.
- Every frame is at least twice the word length.

The stimulus holds each bit-clock phase for four system-clock cycles and moves frame sync only in the cycle where it drops the bit clock. Random frame lengths are drawn from 2N up to 2N+5. Shorter, truncated frames are never generated.

// File: rtl/dsp_ser_pkg.sv
`timescale 1ns/1ps
package dsp_ser_pkg;
    localparam int WORD_MAX = 32;
    localparam int CNT_W    = $clog2(2 * WORD_MAX + 1);

    typedef enum logic [1:0] {
        WLEN_16 = 2'b00,
        WLEN_20 = 2'b01,
        WLEN_24 = 2'b10,
        WLEN_32 = 2'b11
    } wlen_e;

    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] sel);
        case (wlen_e'(sel))
            WLEN_16: wlen_bits = CNT_W'(16);
            WLEN_20: wlen_bits = CNT_W'(20);
            WLEN_24: wlen_bits = CNT_W'(24);
            default: wlen_bits = CNT_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/dsp_edge_sync.sv
`timescale 1ns/1ps
module dsp_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic fall_evt,
    output logic frame_start
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bclk_sr;
        logic [SYNC_STAGES-1:0] fsync_sr;
        logic                   bclk_prev;
        logic                   fsync_at_fall;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic        fall_w;
    logic        start_w;

    always_comb begin
        state_d = state_q;
        fall_w  = state_q.bclk_prev & ~state_q.bclk_sr[LAST];
        start_w = fall_w & state_q.fsync_sr[LAST] & ~state_q.fsync_at_fall;
        if (SYNC_STAGES > 1) begin
            state_d.bclk_sr  = {state_q.bclk_sr[SYNC_STAGES-2:0], bclk};
            state_d.fsync_sr = {state_q.fsync_sr[SYNC_STAGES-2:0], fsync};
        end else begin
            state_d.bclk_sr  = {SYNC_STAGES{bclk}};
            state_d.fsync_sr = {SYNC_STAGES{fsync}};
        end
        state_d.bclk_prev = state_q.bclk_sr[LAST];
        if (fall_w) begin
            state_d.fsync_at_fall = state_q.fsync_sr[LAST];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fall_evt    = fall_w;
    assign frame_start = start_w;

    // Falling edges need at least one high sample in between, so starts are isolated.
    assert_start_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_fall_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);
endmodule

// File: rtl/dsp_word_shifter.sv
`timescale 1ns/1ps
module dsp_word_shifter
    import dsp_ser_pkg::*;
#(
    parameter int WORD_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              start,
    input  logic [1:0]        wl_sel,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdo,
    output logic              load_ack
);
    localparam int CW = $clog2(2 * WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic [CW-1:0]     len;
        logic [CW-1:0]     cnt;
        logic              active;
        logic              sdo;
        logic              ack;
    } shift_state_t;

    shift_state_t      state_d, state_q;
    logic [CW-1:0]     new_len;
    logic [CW-1:0]     pair_len;
    logic [CW-1:0]     bit_idx;
    logic [WORD_W-1:0] picked;
    logic [WORD_W-1:0] new_msb_vec;

    always_comb begin
        state_d     = state_q;
        state_d.ack = 1'b0;
        new_len     = CW'(wlen_bits(wl_sel));
        pair_len    = state_q.len << 1;
        bit_idx     = '0;
        picked      = '0;
        new_msb_vec = left_in >> (new_len - CW'(1));
        if (start) begin
            state_d.left   = left_in;
            state_d.right  = right_in;
            state_d.len    = new_len;
            state_d.cnt    = CW'(1);
            state_d.active = 1'b1;
            state_d.ack    = 1'b1;
            state_d.sdo    = new_msb_vec[0];
        end else if (shift_en && state_q.active) begin
            if (state_q.cnt == pair_len) begin
                state_d.active = 1'b0;
                state_d.sdo    = 1'b0;
            end else begin
                if (state_q.cnt < state_q.len) begin
                    bit_idx = state_q.len - CW'(1) - state_q.cnt;
                    picked  = state_q.left >> bit_idx;
                end else begin
                    bit_idx = pair_len - CW'(1) - state_q.cnt;
                    picked  = state_q.right >> bit_idx;
                end
                state_d.sdo = picked[0];
                state_d.cnt = state_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sdo      = state_q.sdo;
    assign load_ack = state_q.ack;

    logic [WORD_W-1:0] held_msb_vec;
    assign held_msb_vec = state_q.left >> (state_q.len - CW'(1));

    assert_msb_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |-> (sdo == held_msb_vec[0]));

    assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($past(shift_en) || $past(start)));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.active |-> (state_q.cnt <= (state_q.len << 1)));

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.active && !$past(start)) |-> !sdo);

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> !load_ack);
endmodule

// File: rtl/dsp_late_serializer.sv
`timescale 1ns/1ps
module dsp_late_serializer
    import dsp_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [1:0]        wl_sel,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdo,
    output logic              load_ack
);
    logic fall_evt;
    logic frame_start;

    dsp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk        (bclk),
        .fsync       (fsync),
        .fall_evt    (fall_evt),
        .frame_start (frame_start)
    );

    dsp_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (fall_evt),
        .start    (frame_start),
        .wl_sel   (wl_sel),
        .left_in  (left_in),
        .right_in (right_in),
        .sdo      (sdo),
        .load_ack (load_ack)
    );

    assert_ack_follows_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |-> $past(fall_evt));
endmodule

// File: tb/dsp_late_serializer_test.sv
`timescale 1ns/1ps
module dsp_late_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        fsync = 1'b0;
    logic [1:0]  wl_sel = 2'b00;
    logic [31:0] left_in = '0;
    logic [31:0] right_in = '0;
    logic        sdo;
    logic        load_ack;

    int checks = 0;
    int fails = 0;
    int ack_cnt = 0;

    always #5 clk = ~clk;

    dsp_late_serializer uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .wl_sel(wl_sel), .left_in(left_in), .right_in(right_in),
        .sdo(sdo), .load_ack(load_ack)
    );

    always @(posedge clk) if (rst_n && load_ack) ack_cnt <= ack_cnt + 1;

    function automatic int len_of(input logic [1:0] wl);
        case (wl)
            2'b00: return 16;
            2'b01: return 20;
            2'b10: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic exp_bit(input logic [1:0] wl, input logic [31:0] l,
                                     input logic [31:0] r, input int k);
        int n = len_of(wl);
        if (k < n) return l[n-1-k];
        if (k < 2*n) return r[2*n-1-k];
        return 1'b0;
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_bits(input int nbits);
        ack_cnt = 0;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk); bclk = 1'b0; fsync = 1'b0;
            repeat (4) @(negedge clk); bclk = 1'b1;
            check(sdo, 1'b0, "R6", "idle line");
            repeat (3) @(negedge clk);
        end
        check_int(ack_cnt, 0, "R8", "no strobe while idle");
    endtask

    task automatic run_frame(input logic [1:0] wl, input logic [31:0] l, input logic [31:0] r,
                             input int fs_bits, input int nbits, input bit mutate, input string tag);
        int n = len_of(wl);
        logic hold;
        string req;
        wl_sel = wl; left_in = l; right_in = r;
        ack_cnt = 0;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk); bclk = 1'b0; fsync = (k < fs_bits);
            if (mutate && k == 2) begin
                left_in = $urandom; right_in = $urandom; wl_sel = 2'($urandom);
            end
            repeat (4) @(negedge clk); bclk = 1'b1;
            if (k == 0) req = "R2";
            else if (k < n) req = "R4";
            else if (k < 2*n) req = "R5";
            else req = "R6";
            if (mutate) req = {req, "/R7"};
            if (fs_bits > 1) req = {req, "/R9"};
            check(sdo, exp_bit(wl, l, r, k), req, $sformatf("%s bit %0d", tag, k));
            hold = sdo;
            repeat (3) @(negedge clk);
            check(sdo, hold, "R3", $sformatf("%s hold bit %0d", tag, k));
        end
        check_int(ack_cnt, 1, "R8", {tag, " strobe count"});
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(sdo, 1'b0, "R1", "sdo in reset");
        check(load_ack, 1'b0, "R1", "load_ack in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo, 1'b0, "R1", "sdo after reset");
        idle_bits(3);

        run_frame(2'b00, 32'h0000_A5C3, 32'h0000_3C5A, 1, 36, 0, "wl16");
        run_frame(2'b01, 32'h000F_0F0F, 32'h0008_0001, 1, 44, 0, "wl20");
        run_frame(2'b10, 32'h00FF_0001, 32'h0080_0000, 1, 50, 0, "wl24");
        run_frame(2'b11, 32'hDEAD_BEEF, 32'h1234_5678, 1, 66, 0, "wl32");
        run_frame(2'b00, 32'hFFFF_8001, 32'h0000_FFFF, 1, 32, 0, "tight16a");
        run_frame(2'b00, 32'h0000_8000, 32'hFFFF_0001, 1, 32, 0, "tight16b");
        run_frame(2'b11, 32'h8000_0001, 32'h7FFF_FFFE, 5, 64, 0, "longsync");
        run_frame(2'b01, 32'hABCD_E123, 32'h9876_5432, 1, 42, 1, "mutate");
        idle_bits(2);

        for (int i = 0; i < 24; i++) begin
            logic [1:0] wl = 2'($urandom);
            int n = len_of(wl);
            run_frame(wl, $urandom, $urandom, 1 + ($urandom % 3),
                      2*n + ($urandom % 6), 1'($urandom), $sformatf("rnd%0d", i));
        end
        idle_bits(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule